// File: doc/BRIEF.md
# Framed Packet Transmit Sequencer

This block drives one framed packet at a time from a byte FIFO into a downstream serial framer. Each frame goes out as an opening flag byte, the payload bytes read from the FIFO, a two-byte frame check sequence and a closing flag byte. A select input chooses how the payload ends. In length mode, a byte count assembled from a high part and a low part sets the payload length. In tag mode, a marker bit stored beside each FIFO byte ends the payload after the marked byte.

Transmission starts on its own once the FIFO holds data. It can instead be held back until a start strobe arrives, which lets software queue a whole short frame before any of it is sent. If the FIFO runs dry before the payload end, the block can react in one of two ways. By default it closes the frame with a deliberately wrong check sequence and then refuses further frames until a resume strobe arrives while the FIFO is empty. When underrun handling is disabled, it keeps the line idle and carries on once more bytes appear.

The FIFO is show-ahead: its head byte and marker are visible while it is not empty, and `fifo_pop` removes the head. The framer takes a byte on any cycle where `tx_valid` and `tx_ready` are both high.

Top module: `framed_tx_ctrl`

## Requirements
- R1: While `rst_n` is low, and until data arrives after reset, `tx_valid`, `fifo_pop` and `locked` are all 0.
- R2: A frame is sent in this order: flag 0x7E, the payload bytes in FIFO order, check byte low, check byte high, flag 0x7E. `tx_is_flag` is 1 for the two flag bytes only, even when a payload byte equals 0x7E.
- R3: The check sequence is CRC-16 over the payload with polynomial 0x1021, fed MSB first, preset 0xFFFF. On a normal frame it is sent one's-complemented.
- R4: With `end_sel`=0 (length mode), the payload ends after {`len_hi`,`len_lo`} bytes (12 bits, counted from 1). The FIFO marker bit is ignored.
- R5: With `end_sel`=1 (tag mode), the payload ends after the first byte whose `fifo_tag` is 1. The length inputs are ignored.
- R6: With `defer_en`=0, a frame starts by itself as soon as the FIFO is not empty and the block is not locked.
- R7: With `defer_en`=1, no byte is sent while the FIFO holds data until a `start_strobe` pulse arrives. The pulse is remembered until a frame starts.
- R8: A byte is transferred only when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_byte` stays stable. `fifo_pop` is raised once for each transferred payload byte, and never while the FIFO is empty.
- R9: With `urun_off`=0, an empty FIFO in the middle of a payload ends the payload. The check bytes are then sent without the complement, followed by the closing flag, and `locked` becomes 1.
- R10: While `locked` is 1, nothing is sent and the FIFO is not popped. `resume_strobe` clears `locked` only in a cycle where `fifo_empty` is 1.
- R11: With `urun_off`=1, an empty FIFO in the middle of a payload holds `tx_valid` low. The frame continues when bytes arrive, ends with a correct check sequence and leaves `locked` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| end_sel | input | 1 | 0: length mode, 1: tag mode |
| defer_en | input | 1 | Hold each frame until a start strobe |
| start_strobe | input | 1 | One-cycle start request for deferred mode |
| urun_off | input | 1 | 1 disables underrun abort and lockout |
| resume_strobe | input | 1 | One-cycle request to leave the locked state |
| len_hi | input | 4 | Upper bits of the payload length |
| len_lo | input | 8 | Lower bits of the payload length |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_tag | input | 1 | End marker stored with the head byte |
| fifo_pop | output | 1 | Remove the head byte |
| tx_valid | output | 1 | A byte is offered to the framer |
| tx_byte | output | 8 | Offered byte |
| tx_is_flag | output | 1 | Offered byte is a frame flag |
| tx_ready | input | 1 | Framer accepts the offered byte |
| locked | output | 1 | Transmit lockout after an underrun |

## Verification
A table of frames covers both end modes. In some rows the unused end source points to a different length, so a design that looks at the wrong source gives a different byte count. A payload byte equal to the flag value separates data from flags. Rows that alternate `tx_ready` check that bytes are neither dropped nor repeated under backpressure. Directed cases cover deferred start, an underrun with the CRC left uncomplemented and the lockout that follows, a resume attempt while the FIFO still holds data, and an underrun with handling disabled, where the stalled frame has to finish with a correct CRC.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_DATA,
        ST_CRCL,
        ST_CRCH,
        ST_EOF,
        ST_LOCK
    } ftx_state_e;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
endpackage

// File: rtl/ftx_crc_step.sv
module ftx_crc_step #(
    parameter int          DATA_W = 8,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ byte_in[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_W'(POLY) : '0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/ftx_end_detect.sv
module ftx_end_detect #(
    parameter int LEN_W = 12
) (
    input  logic             end_sel,
    input  logic [LEN_W-1:0] sent_cnt,
    input  logic [LEN_W-1:0] target_len,
    input  logic             tag_bit,
    output logic             last_byte
);
    logic [LEN_W-1:0] next_cnt;

    assign next_cnt  = sent_cnt + LEN_W'(1);
    assign last_byte = end_sel ? tag_bit : (next_cnt == target_len);
endmodule

// File: rtl/framed_tx_ctrl.sv
module framed_tx_ctrl #(
    parameter int          DATA_W    = 8,
    parameter int          LEN_W     = 12,
    parameter logic [15:0] CRC_POLY  = 16'h1021,
    parameter logic [15:0] CRC_PRESET = 16'hFFFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      end_sel,
    input  logic                      defer_en,
    input  logic                      start_strobe,
    input  logic                      urun_off,
    input  logic                      resume_strobe,
    input  logic [LEN_W-DATA_W-1:0]   len_hi,
    input  logic [DATA_W-1:0]         len_lo,
    input  logic                      fifo_empty,
    input  logic [DATA_W-1:0]         fifo_data,
    input  logic                      fifo_tag,
    output logic                      fifo_pop,
    output logic                      tx_valid,
    output logic [DATA_W-1:0]         tx_byte,
    output logic                      tx_is_flag,
    input  logic                      tx_ready,
    output logic                      locked
);
    import ftx_pkg::*;

    localparam int CRC_W = 2 * DATA_W;

    typedef struct packed {
        ftx_state_e       st;
        logic [LEN_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             bad;
        logic             pend;
    } ftx_regs_t;

    ftx_regs_t        r_q, r_d;
    logic [CRC_W-1:0] crc_upd;
    logic             is_last;
    logic [LEN_W-1:0] target_len;
    logic [CRC_W-1:0] crc_wire;

    assign target_len = {len_hi, len_lo};
    assign crc_wire   = r_q.bad ? r_q.crc : ~r_q.crc;

    ftx_crc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_in  (r_q.crc),
        .byte_in (fifo_data),
        .crc_out (crc_upd)
    );

    ftx_end_detect #(.LEN_W(LEN_W)) u_end (
        .end_sel    (end_sel),
        .sent_cnt   (r_q.cnt),
        .target_len (target_len),
        .tag_bit    (fifo_tag),
        .last_byte  (is_last)
    );

    always_comb begin
        r_d        = r_q;
        tx_valid   = 1'b0;
        tx_byte    = DATA_W'(FLAG_BYTE);
        tx_is_flag = 1'b0;
        fifo_pop   = 1'b0;
        if (start_strobe) r_d.pend = 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!fifo_empty && (!defer_en || r_q.pend)) begin
                    r_d.st   = ST_SOF;
                    r_d.pend = 1'b0;
                end
            end
            ST_SOF: begin
                tx_valid   = 1'b1;
                tx_is_flag = 1'b1;
                if (tx_ready) begin
                    r_d.st  = ST_DATA;
                    r_d.cnt = '0;
                    r_d.crc = CRC_W'(CRC_PRESET);
                    r_d.bad = 1'b0;
                end
            end
            ST_DATA: begin
                if (!fifo_empty) begin
                    tx_valid = 1'b1;
                    tx_byte  = fifo_data;
                    if (tx_ready) begin
                        fifo_pop = 1'b1;
                        r_d.cnt  = r_q.cnt + LEN_W'(1);
                        r_d.crc  = crc_upd;
                        if (is_last) r_d.st = ST_CRCL;
                    end
                end else if (!urun_off) begin
                    r_d.bad = 1'b1;
                    r_d.st  = ST_CRCL;
                end
            end
            ST_CRCL: begin
                tx_valid = 1'b1;
                tx_byte  = crc_wire[DATA_W-1:0];
                if (tx_ready) r_d.st = ST_CRCH;
            end
            ST_CRCH: begin
                tx_valid = 1'b1;
                tx_byte  = crc_wire[CRC_W-1:DATA_W];
                if (tx_ready) r_d.st = ST_EOF;
            end
            ST_EOF: begin
                tx_valid   = 1'b1;
                tx_is_flag = 1'b1;
                if (tx_ready) r_d.st = r_q.bad ? ST_LOCK : ST_IDLE;
            end
            ST_LOCK: begin
                if (resume_strobe && fifo_empty) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.crc  <= CRC_W'(CRC_PRESET);
            r_q.bad  <= 1'b0;
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign locked = (r_q.st == ST_LOCK);
endmodule

// File: rtl/framed_tx_ctrl_chk.sv
module framed_tx_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty,
    input logic              fifo_pop,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_byte,
    input logic              tx_is_flag,
    input logic              tx_ready,
    input logic              resume_strobe,
    input logic              locked
);
    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!fifo_empty && tx_valid && tx_ready));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R10
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!tx_valid && !fifo_pop));

    // R10
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(resume_strobe && fifo_empty));

    // R2
    flag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_is_flag) |-> (tx_byte == DATA_W'(8'h7E)));
endmodule

bind framed_tx_ctrl framed_tx_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_empty    (fifo_empty),
    .fifo_pop      (fifo_pop),
    .tx_valid      (tx_valid),
    .tx_byte       (tx_byte),
    .tx_is_flag    (tx_is_flag),
    .tx_ready      (tx_ready),
    .resume_strobe (resume_strobe),
    .locked        (locked)
);

// File: tb/framed_tx_ctrl_bench.sv
`timescale 1ns/1ps
module framed_tx_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       end_sel = 1'b0, defer_en = 1'b0, start_strobe = 1'b0;
    logic       urun_off = 1'b0, resume_strobe = 1'b0;
    logic [3:0] len_hi = '0;
    logic [7:0] len_lo = '0;
    logic       fifo_empty, fifo_tag, fifo_pop;
    logic [7:0] fifo_data;
    logic       tx_valid, tx_is_flag, locked;
    logic [7:0] tx_byte;
    logic       tx_ready = 1'b1;
    logic       rdy_alt = 1'b0;

    always #2 clk = ~clk;

    framed_tx_ctrl u_framed_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .end_sel(end_sel), .defer_en(defer_en),
        .start_strobe(start_strobe), .urun_off(urun_off),
        .resume_strobe(resume_strobe), .len_hi(len_hi), .len_lo(len_lo),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_tag(fifo_tag),
        .fifo_pop(fifo_pop), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_is_flag(tx_is_flag), .tx_ready(tx_ready), .locked(locked)
    );

    // FIFO model and output capture
    logic [8:0] mem [0:63];
    logic [5:0] rd = '0, wr = '0, push_req = '0;
    logic       flush_req = 1'b0, cap_clr = 1'b0;
    logic [8:0] cap [0:63];
    int         cap_n = 0;

    assign fifo_empty = (rd == wr);
    assign fifo_data  = mem[rd][7:0];
    assign fifo_tag   = mem[rd][8];

    always @(posedge clk) begin
        if (flush_req) rd <= wr;
        else if (fifo_pop) rd <= rd + 6'd1;
        wr <= wr + push_req;
        if (cap_clr) cap_n <= 0;
        else if (tx_valid && tx_ready) begin
            if (cap_n < 64) cap[cap_n] <= {tx_is_flag, tx_byte};
            cap_n <= cap_n + 1;
        end
    end

    always @(negedge clk) tx_ready <= rdy_alt ? ~tx_ready : 1'b1;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [8:0] exp_f [0:63];
    int exp_n;

    typedef struct packed {
        logic       alt;
        logic       mode;
        logic [11:0] len;
        logic [7:0] n;
        logic [7:0] tagpos;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{1'b0, 1'b0, 12'd3, 8'd3, 8'd0,   8'h11},
        '{1'b1, 1'b0, 12'd1, 8'd1, 8'd255, 8'h7E},
        '{1'b0, 1'b1, 12'd2, 8'd5, 8'd4,   8'hA0},
        '{1'b1, 1'b1, 12'd0, 8'd1, 8'd0,   8'h00},
        '{1'b0, 1'b0, 12'd8, 8'd8, 8'd255, 8'hF3}
    };

    function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
        return 8'(seed + 8'(i * 37));
    endfunction

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
        return x;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int n, input logic [7:0] seed, input int tagpos, input int base);
        @(negedge clk);
        for (int i = 0; i < n; i++)
            mem[6'(wr + 6'(i))] = {1'b0, pay(seed, base + i)} | {(base + i) == tagpos, 8'h00};
        push_req = 6'(n);
        @(negedge clk);
        push_req = '0;
    endtask

    task automatic clear_cap();
        @(negedge clk); cap_clr = 1'b1;
        @(negedge clk); cap_clr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic build_exp(input int n, input logic [7:0] seed, input bit bad);
        logic [15:0] c;
        c = 16'hFFFF;
        exp_f[0] = {1'b1, 8'h7E};
        for (int i = 0; i < n; i++) begin
            exp_f[1 + i] = {1'b0, pay(seed, i)};
            c = crc_add(c, pay(seed, i));
        end
        if (!bad) c = ~c;
        exp_f[n + 1] = {1'b0, c[7:0]};
        exp_f[n + 2] = {1'b0, c[15:8]};
        exp_f[n + 3] = {1'b1, 8'h7E};
        exp_n = n + 4;
    endtask

    task automatic chk_frame(input string req, input string what);
        int bad_at;
        bad_at = -1;
        checks++;
        if (cap_n != exp_n) begin
            errors++;
            $display("FAIL %s %s: actual=%0d bytes expected=%0d bytes", req, what, cap_n, exp_n);
        end else begin
            for (int i = 0; i < exp_n; i++)
                if (bad_at < 0 && cap[i] != exp_f[i]) bad_at = i;
            if (bad_at >= 0) begin
                errors++;
                $display("FAIL %s %s: byte %0d actual=%h expected=%h", req, what,
                         bad_at, cap[bad_at], exp_f[bad_at]);
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_strobe = 1'b1;
        @(negedge clk); start_strobe = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk); resume_strobe = 1'b1;
        @(negedge clk); resume_strobe = 1'b0;
    endtask

    initial begin
        // R1: reset state
        wait_cyc(3);
        chk("R1", tx_valid, 0, "tx_valid in reset");
        chk("R1", fifo_pop, 0, "fifo_pop in reset");
        chk("R1", locked, 0, "locked in reset");
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R1", cap_n, 0, "bytes sent with empty FIFO after reset");

        // Table of frames: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < 5; v++) begin
            rdy_alt = VEC[v].alt;
            end_sel = VEC[v].mode;
            len_hi  = VEC[v].len[11:8];
            len_lo  = VEC[v].len[7:0];
            clear_cap();
            push(int'(VEC[v].n), VEC[v].seed, int'(VEC[v].tagpos), 0);
            wait_cyc(80);
            build_exp(int'(VEC[v].n), VEC[v].seed, 1'b0);
            chk_frame(VEC[v].mode ? "R5/R2/R3" : "R4/R2/R3", $sformatf("vector %0d", v));
            chk("R8", int'(wr - rd), 0, $sformatf("bytes left in FIFO, vector %0d", v));
        end
        rdy_alt = 1'b0;

        // R7: deferred start
        defer_en = 1'b1; end_sel = 1'b1;
        clear_cap();
        push(2, 8'h5C, 1, 0);
        wait_cyc(40);
        chk("R7", cap_n, 0, "bytes sent before start strobe");
        chk("R7", int'(wr - rd), 2, "FIFO entries held before start strobe");
        pulse_start();
        wait_cyc(40);
        build_exp(2, 8'h5C, 1'b0);
        chk_frame("R7", "frame after start strobe");
        defer_en = 1'b0;

        // R9: underrun with handling on
        end_sel = 1'b0; len_hi = 4'd0; len_lo = 8'd5;
        clear_cap();
        push(2, 8'h33, 255, 0);
        wait_cyc(40);
        build_exp(2, 8'h33, 1'b1);
        chk_frame("R9", "underrun frame with raw CRC");
        chk("R9", locked, 1, "locked after underrun");

        // R10: lockout and resume
        clear_cap();
        push(2, 8'h44, 255, 0);
        wait_cyc(30);
        chk("R10", cap_n, 0, "bytes sent while locked");
        chk("R10", int'(wr - rd), 2, "FIFO entries while locked");
        pulse_resume();
        wait_cyc(3);
        chk("R10", locked, 1, "locked after resume with FIFO not empty");
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        pulse_resume();
        wait_cyc(3);
        chk("R10", locked, 0, "locked after flush and resume");
        chk("R10", cap_n, 0, "bytes sent after resume with empty FIFO");

        // R11: underrun handling off
        urun_off = 1'b1; len_lo = 8'd4;
        clear_cap();
        push(2, 8'h91, 255, 0);
        wait_cyc(40);
        chk("R11", cap_n, 3, "bytes sent while stalled");
        chk("R11", int'(tx_valid), 0, "tx_valid while stalled");
        push(2, 8'h91, 255, 2);
        wait_cyc(40);
        build_exp(4, 8'h91, 1'b0);
        chk_frame("R11", "resumed frame");
        chk("R11", locked, 0, "locked after stalled frame");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule